// File: doc/BRIEF.md
# Counter-Timed One-Shot Pulse Generator

This block turns a rising edge on a trigger input into a single output pulse whose length is an exact number of clock cycles. The length comes from a down-counter, not from any analog timing element. The trigger is registered in the block's own clock domain, and only its low-to-high transitions count. A level held high produces one pulse.

The width comes from one of two sources, chosen at elaboration. It is either the run-time input `width_i`, captured when a trigger is accepted, or the parameter `DEF_WIDTH`. A mode input selects how an edge that arrives during a pulse is handled. In one-shot mode the edge is discarded. In restart mode the counter reloads, which stretches the pulse. Both modes accept an edge that lands in the last cycle of a pulse, and the pulse then continues without a gap.

Top module: `oneshot_gen`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is 0. After reset is released, `pulse_o` stays 0 until a new trigger edge is accepted, even if reset was applied in the middle of a pulse.
- R2: Only a rising transition of the registered trigger is an event. A trigger held high for many cycles gives exactly one pulse.
- R3: If `trig_i` is first sampled high at clock edge k, `pulse_o` goes high just after edge k+1. Nothing changes after edge k.
- R4: An accepted trigger with no later accepted edge gives a pulse that is high for exactly W clock cycles. W is the effective width.
- R5: A width value of 0 is treated as 1, so the pulse is one cycle long.
- R6: With `retrig_i` = 0 (one-shot mode), an edge detected while more than one cycle of the pulse remains is ignored, and the pulse ends at its original time.
- R7: With `retrig_i` = 1 (restart mode), every detected edge reloads the counter. The pulse ends W cycles after the load caused by the last edge.
- R8: An edge detected in the final cycle of a pulse is accepted in both modes. The pulse then runs for W more cycles with no low cycle in between.
- R9: With `WIDTH_FROM_PORT` = 0, the width is `DEF_WIDTH` and `width_i` has no effect. With `WIDTH_FROM_PORT` = 1, `width_i` is captured at the cycle the edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger, already in the clock domain |
| retrig_i | input | 1 | 1 = restart mode, 0 = one-shot mode |
| width_i | input | CNT_W | Pulse width in cycles (0 means 1), used when WIDTH_FROM_PORT = 1 |
| pulse_o | output | 1 | Pulse output, high while the counter is non-zero |

## Verification
The output is high exactly while the down-counter is non-zero, so any error in the counter shows up as a change in the pulse length. A wrong load value, a missed decrement or an accept decision that should have gone the other way all show at `pulse_o`. The error appears either on the first cycle of the pulse or on the cycle where it should have ended. Each scenario records `pulse_o` in every cycle of a 16-cycle window and compares the whole pattern. An edge detector that is off by one, a wrong last-cycle acceptance rule or a missing width clamp therefore each show as a shifted, stretched or split pulse within a few cycles of the trigger.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   typedef enum logic {
      OS_MODE_SINGLE  = 1'b0,
      OS_MODE_RESTART = 1'b1
   } os_mode_e;
endpackage

// File: rtl/oneshot_edge.sv
module oneshot_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic rise_o
);
   logic trig_q;
   logic trig_qq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q  <= 1'b0;
         trig_qq <= 1'b0;
      end else begin
         trig_q  <= trig_i;
         trig_qq <= trig_q;
      end
   end

   assign rise_o = trig_q & ~trig_qq;
endmodule

// File: rtl/oneshot_width.sv
module oneshot_width #(
   parameter int unsigned CNT_W           = 8,
   parameter bit          WIDTH_FROM_PORT = 1'b1,
   parameter int unsigned DEF_WIDTH       = 4
) (
   input  logic [CNT_W-1:0] width_i,
   output logic [CNT_W-1:0] width_o
);
   localparam int unsigned FIXED_W = (DEF_WIDTH == 0) ? 1 : DEF_WIDTH;

   generate
      if (WIDTH_FROM_PORT) begin : g_port
         assign width_o = (width_i == '0) ? CNT_W'(1) : width_i;
      end else begin : g_fixed
         logic [CNT_W-1:0] unused_w;
         assign unused_w = width_i;
         assign width_o  = CNT_W'(FIXED_W);
      end
   endgenerate
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
   import oneshot_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  os_mode_e         mode_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             load_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             idle_or_last;

   assign idle_or_last = (cnt_q <= CNT_W'(1));
   assign load_o       = rise_i & ((mode_i == OS_MODE_RESTART) | idle_or_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_o) begin
         cnt_q <= width_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen
   import oneshot_pkg::*;
#(
   parameter int unsigned CNT_W           = 8,
   parameter bit          WIDTH_FROM_PORT = 1'b1,
   parameter int unsigned DEF_WIDTH       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             retrig_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             pulse_o
);
   localparam longint unsigned MAX_W = (64'd1 << CNT_W) - 1;

   initial begin
      if (CNT_W < 1 || CNT_W > 32)
         $error("oneshot_gen: CNT_W must be in 1..32");
      if (!WIDTH_FROM_PORT && (DEF_WIDTH > MAX_W))
         $error("oneshot_gen: DEF_WIDTH does not fit in CNT_W bits");
   end

   logic             rise;
   logic             load;
   logic [CNT_W-1:0] width_eff;
   logic [CNT_W-1:0] cnt;
   os_mode_e         mode;

   assign mode = os_mode_e'(retrig_i);

   oneshot_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i),
      .rise_o (rise)
   );

   oneshot_width #(
      .CNT_W           (CNT_W),
      .WIDTH_FROM_PORT (WIDTH_FROM_PORT),
      .DEF_WIDTH       (DEF_WIDTH)
   ) u_width (
      .width_i (width_i),
      .width_o (width_eff)
   );

   oneshot_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise),
      .mode_i  (mode),
      .width_i (width_eff),
      .load_o  (load),
      .cnt_o   (cnt)
   );

   assign pulse_o = (cnt != '0);
endmodule

// File: rtl/oneshot_gen_chk.sv
module oneshot_gen_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             retrig_i,
   input logic             rise,
   input logic             load,
   input logic [CNT_W-1:0] width_eff,
   input logic [CNT_W-1:0] cnt,
   input logic             pulse_o
);
   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_o && !rise) |=> !pulse_o);

   p_edge_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !pulse_o) |=> pulse_o);

   p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(width_eff)));

   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && !load) |=> (cnt == $past(cnt) - CNT_W'(1)));

   p_min_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (width_eff != '0));

   p_single_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!retrig_i && rise && (cnt > CNT_W'(1))) |=> (cnt == $past(cnt) - CNT_W'(1)));

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (retrig_i && rise) |=> (cnt == $past(width_eff)));

   p_last_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && (cnt == CNT_W'(1))) |=> pulse_o);
endmodule

bind oneshot_gen oneshot_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .retrig_i  (retrig_i),
   .rise      (rise),
   .load      (load),
   .width_eff (width_eff),
   .cnt       (cnt),
   .pulse_o   (pulse_o)
);

// File: tb/sim_oneshot_gen.sv
`timescale 1ns/1ps
module sim_oneshot_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_i = 1'b0;
   logic       retrig_i = 1'b0;
   logic [7:0] width_i = 8'd4;
   logic       pulse_o;
   logic       pulse_fix;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   oneshot_gen #(.CNT_W(8), .WIDTH_FROM_PORT(1'b1), .DEF_WIDTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .retrig_i(retrig_i),
      .width_i(width_i), .pulse_o(pulse_o)
   );

   oneshot_gen #(.CNT_W(8), .WIDTH_FROM_PORT(1'b0), .DEF_WIDTH(6)) u1 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .retrig_i(retrig_i),
      .width_i(width_i), .pulse_o(pulse_fix)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // bit i of the pattern is driven at the i-th falling edge, after pulse_o is sampled there
   task automatic run_window(input string req, input logic mode, input logic [7:0] w,
                             input logic [15:0] pat, input logic [15:0] exp,
                             input bit chk_fix, input logic [15:0] exp_fix);
      logic [15:0] got;
      logic [15:0] got_fix;
      @(negedge clk);
      retrig_i = mode;
      width_i  = w;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         got[i]     = pulse_o;
         got_fix[i] = pulse_fix;
         trig_i     = pat[i];
      end
      trig_i = 1'b0;
      check(req, got, exp);
      if (chk_fix) check({req, " fixed-width"}, got_fix, exp_fix);
      repeat (20) @(negedge clk);
      check({req, " idle after"}, {15'd0, pulse_o}, 16'd0);
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      check("R1 in reset", {15'd0, pulse_o}, 16'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after release", {15'd0, pulse_o}, 16'd0);
   endtask

   task automatic t_isolated;
      // R3 R4 R9: high from negedge 2, width 5 on port instance, 6 on fixed one
      run_window("R4 isolated w5", 1'b0, 8'd5, 16'h0001, 16'h007C, 1'b1, 16'h00FC);
      run_window("R3 R4 w1", 1'b0, 8'd1, 16'h0001, 16'h0004, 1'b0, 16'h0);
      run_window("R5 w0", 1'b0, 8'd0, 16'h0001, 16'h0004, 1'b1, 16'h00FC);
   endtask

   task automatic t_level_hold;
      run_window("R2 held level", 1'b1, 8'd3, 16'hFFFF, 16'h001C, 1'b0, 16'h0);
   endtask

   task automatic t_mid_pulse;
      run_window("R6 single ignores", 1'b0, 8'd8, 16'h0011, 16'h03FC, 1'b0, 16'h0);
      run_window("R6 single ignores near end", 1'b0, 8'd4, 16'h0009, 16'h003C, 1'b0, 16'h0);
      run_window("R7 restart stretches", 1'b1, 8'd8, 16'h0011, 16'h3FFC, 1'b0, 16'h0);
   endtask

   task automatic t_last_cycle;
      run_window("R8 last cycle single", 1'b0, 8'd4, 16'h0011, 16'h03FC, 1'b0, 16'h0);
      run_window("R8 last cycle restart", 1'b1, 8'd4, 16'h0011, 16'h03FC, 1'b0, 16'h0);
   endtask

   task automatic t_back_to_back;
      run_window("R7 burst restart", 1'b1, 8'd3, 16'h0015, 16'h01FC, 1'b0, 16'h0);
      run_window("R6 burst single", 1'b0, 8'd3, 16'h0015, 16'h01DC, 1'b0, 16'h0);
   endtask

   task automatic t_reset_mid_pulse;
      @(negedge clk);
      retrig_i = 1'b0;
      width_i  = 8'd10;
      trig_i   = 1'b1;
      repeat (4) @(negedge clk);
      trig_i = 1'b0;
      check("R1 pulse running before reset", {15'd0, pulse_o}, 16'd1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid pulse", {15'd0, pulse_o}, 16'd0);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      check("R1 stays low after reset", {15'd0, pulse_o}, 16'd0);
   endtask

   initial begin
      t_reset_state();
      t_isolated();
      t_level_hold();
      t_mid_pulse();
      t_last_cycle();
      t_back_to_back();
      t_reset_mid_pulse();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule